// File: doc/BRIEF.md
# Parallel Port Peripheral Handshake Responder

This block sits on the peripheral end of an enhanced parallel port cable and answers the transfer handshake that the host starts. The host pulls either its address strobe or its data strobe low. The write line tells the block the direction: low for host-to-peripheral, high for peripheral-to-host. The block holds its wait output low while it is ready. It raises that output once it has dealt with the byte, which is the acknowledge. It lowers the output again only after the host has released the strobe.

Address-strobe cycles use an internal address register. The host can write this register and read it back, and local logic can see its value. Data-strobe cycles go to local logic. A write produces a one-cycle valid pulse that carries the byte. A read returns a byte taken from a local read-data input. Local logic can ask the host for attention through an interrupt line. That request clears when the host completes a data read. A small output register, loaded from the local side, drives the spare host status lines.

The strobe and write inputs are asynchronous to the block clock, so they pass through synchronisers before the state machine sees them.

Top module: `epp_responder`

## Requirements
- R1: After reset, host_wait_n is 0, bus_oe is 0, host_irq is 0, loc_addr is 0, host_status is 0 and loc_wr_valid is 0.
- R2: host_wait_n rises exactly SYNC_STAGES+1 clock edges after a strobe falls. With the default SYNC_STAGES=2 this is 3 edges.
- R3: host_wait_n returns low exactly SYNC_STAGES+1 clock edges after the strobe returns high. After that the next strobe is accepted.
- R4: An address-strobe cycle with host_wr_n low loads bus_in into the address register, which appears on loc_addr. It produces no loc_wr_valid pulse.
- R5: A data-strobe cycle with host_wr_n low produces exactly one loc_wr_valid pulse, one clock long, with the byte on loc_wr_data. The pulse coincides with the rise of host_wait_n. The address register is left unchanged.
- R6: An address-strobe cycle with host_wr_n high drives the address register onto bus_out with bus_oe high while host_wait_n is high.
- R7: A data-strobe cycle with host_wr_n high drives onto bus_out the value of loc_rd_data sampled in the clock where the strobe is detected.
- R8: bus_oe is high only in read cycles and never in write cycles. It goes low one clock after the strobe returns high.
- R9: A one-clock pulse on loc_irq_set raises host_irq. host_irq stays high through address cycles and data writes. It clears when a data-strobe read cycle completes, that is, when host_wait_n returns low. A set in the same clock as that completion wins.
- R10: A pulse on loc_gpo_we loads loc_gpo_din into the register driving host_status. The new value is visible after one clock.
- R11: If both strobes fall together, the cycle is treated as an address-strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| host_astb_n | input | 1 | Host address strobe, active low, asynchronous |
| host_dstb_n | input | 1 | Host data strobe, active low, asynchronous |
| host_wr_n | input | 1 | Direction: low = host writes, high = host reads |
| host_wait_n | output | 1 | Low = ready for a cycle, high = acknowledge |
| bus_in | input | DATA_W (8) | Byte sampled from the shared bus |
| bus_out | output | DATA_W (8) | Byte driven onto the shared bus on reads |
| bus_oe | output | 1 | Output enable for bus_out |
| host_irq | output | 1 | Service request to the host |
| host_status | output | GPO_W (3) | Spare status lines to the host |
| loc_wr_valid | output | 1 | One-clock pulse for each host data write |
| loc_wr_data | output | DATA_W (8) | Byte of the latest host data write |
| loc_rd_data | input | DATA_W (8) | Byte returned on host data reads |
| loc_addr | output | DATA_W (8) | Current address register |
| loc_irq_set | input | 1 | Pulse that raises host_irq |
| loc_gpo_we | input | 1 | Load enable for the status output register |
| loc_gpo_din | input | GPO_W (3) | Value for the status output register |

## Verification
The bench builds the block with its defaults: an 8-bit bus, a 3-bit status register and two synchroniser stages. With these values all 256 byte values can be swept through address writes, address read-back, data writes and data reads. For every cycle the bench measures the acknowledge and release latencies and checks them against the expected three edges. The 3-bit status register is small enough to walk through all eight codes. The interrupt ordering and the case of both strobes falling together are driven as separate sequences.

// File: rtl/epp_resp_pkg.sv
package epp_resp_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } hs_state_e;

    typedef struct packed {
        logic is_addr;
        logic is_read;
    } xfer_kind_t;

    // Address strobe takes priority when both edges land together.
    function automatic xfer_kind_t classify(input logic addr_edge, input logic wr_line_n);
        xfer_kind_t k;
        k.is_addr = addr_edge;
        k.is_read = wr_line_n;
        return k;
    endfunction

    function automatic logic is_data_read(input xfer_kind_t k);
        return k.is_read & ~k.is_addr;
    endfunction

endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
    parameter int              WIDTH     = 3,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[g] <= RESET_VAL;
                end else if (g == 0) begin
                    chain[g] <= d;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/epp_hs_fsm.sv
module epp_hs_fsm
    import epp_resp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       astb_s,
    input  logic       dstb_s,
    input  logic       wr_s,
    input  logic       raw_strobe_low,
    output logic       wait_n,
    output logic       start,
    output xfer_kind_t start_kind,
    output logic       done,
    output xfer_kind_t cur_kind,
    output logic       oe
);
    hs_state_e  state;
    logic       astb_prev, dstb_prev;
    logic       fall_a, fall_d, release_c;
    xfer_kind_t kind_q;
    logic       oe_q;

    assign fall_a     = astb_prev & ~astb_s;
    assign fall_d     = dstb_prev & ~dstb_s;
    assign start      = (state == ST_IDLE) & (fall_a | fall_d);
    assign start_kind = classify(fall_a, wr_s);
    assign release_c  = (state == ST_ACK) & astb_s & dstb_s;
    assign done       = release_c;
    assign cur_kind   = kind_q;
    assign wait_n     = (state == ST_ACK);
    assign oe         = oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            astb_prev <= 1'b1;
            dstb_prev <= 1'b1;
            kind_q    <= '0;
            oe_q      <= 1'b0;
        end else begin
            astb_prev <= astb_s;
            dstb_prev <= dstb_s;
            if (start) begin
                state  <= ST_ACK;
                kind_q <= start_kind;
            end else if (release_c) begin
                state  <= ST_IDLE;
            end
            oe_q <= raw_strobe_low &
                    ((start & start_kind.is_read) |
                     ((state == ST_ACK) & ~release_c & kind_q.is_read));
        end
    end

    // R2: acknowledge only follows a synchronised active strobe
    a_r2_ack_after_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(wait_n) |-> $past(~astb_s | ~dstb_s));

    // R3: ready only returns once both strobes are seen released
    a_r3_ready_after_release: assert property (@(posedge clk) disable iff (rst)
        $fell(wait_n) |-> $past(astb_s & dstb_s));
endmodule

// File: rtl/epp_regs.sv
module epp_regs
    import epp_resp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int GPO_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_kind_t        start_kind,
    input  logic              done,
    input  xfer_kind_t        done_kind,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] loc_rd_data,
    input  logic              irq_set,
    input  logic              gpo_we,
    input  logic [GPO_W-1:0]  gpo_din,
    output logic [DATA_W-1:0] addr_q,
    output logic [DATA_W-1:0] rd_byte,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_data,
    output logic              irq,
    output logic [GPO_W-1:0]  gpo
);
    logic data_rd_done;
    assign data_rd_done = done & is_data_read(done_kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            rd_byte  <= '0;
            wr_valid <= 1'b0;
            wr_data  <= '0;
            irq      <= 1'b0;
            gpo      <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (start & ~start_kind.is_read) begin
                if (start_kind.is_addr) begin
                    addr_q <= bus_in;
                end else begin
                    wr_valid <= 1'b1;
                    wr_data  <= bus_in;
                end
            end
            if (start & is_data_read(start_kind)) begin
                rd_byte <= loc_rd_data;
            end
            if (irq_set) begin
                irq <= 1'b1;
            end else if (data_rd_done) begin
                irq <= 1'b0;
            end
            if (gpo_we) begin
                gpo <= gpo_din;
            end
        end
    end

    // R9: request drops only at the end of a data read
    a_r9_irq_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(data_rd_done));

    // R5: write pulse is a single clock
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);
endmodule

// File: rtl/epp_responder.sv
module epp_responder
    import epp_resp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int GPO_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_astb_n,
    input  logic              host_dstb_n,
    input  logic              host_wr_n,
    output logic              host_wait_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              host_irq,
    output logic [GPO_W-1:0]  host_status,
    output logic              loc_wr_valid,
    output logic [DATA_W-1:0] loc_wr_data,
    input  logic [DATA_W-1:0] loc_rd_data,
    output logic [DATA_W-1:0] loc_addr,
    input  logic              loc_irq_set,
    input  logic              loc_gpo_we,
    input  logic [GPO_W-1:0]  loc_gpo_din
);
    localparam int NCTRL = 3;

    logic [NCTRL-1:0] ctrl_s;
    logic             start, done;
    xfer_kind_t       start_kind, cur_kind;
    logic [DATA_W-1:0] addr_q, rd_byte;

    epp_sync #(
        .WIDTH    (NCTRL),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL('1)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({host_astb_n, host_dstb_n, host_wr_n}),
        .q   (ctrl_s)
    );

    epp_hs_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .astb_s         (ctrl_s[2]),
        .dstb_s         (ctrl_s[1]),
        .wr_s           (ctrl_s[0]),
        .raw_strobe_low (~host_astb_n | ~host_dstb_n),
        .wait_n         (host_wait_n),
        .start          (start),
        .start_kind     (start_kind),
        .done           (done),
        .cur_kind       (cur_kind),
        .oe             (bus_oe)
    );

    epp_regs #(
        .DATA_W (DATA_W),
        .GPO_W  (GPO_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_kind  (start_kind),
        .done        (done),
        .done_kind   (cur_kind),
        .bus_in      (bus_in),
        .loc_rd_data (loc_rd_data),
        .irq_set     (loc_irq_set),
        .gpo_we      (loc_gpo_we),
        .gpo_din     (loc_gpo_din),
        .addr_q      (addr_q),
        .rd_byte     (rd_byte),
        .wr_valid    (loc_wr_valid),
        .wr_data     (loc_wr_data),
        .irq         (host_irq),
        .gpo         (host_status)
    );

    assign bus_out  = cur_kind.is_addr ? addr_q : rd_byte;
    assign loc_addr = addr_q;

    // R8: the bus is only driven inside an acknowledged cycle
    a_r8_oe_inside_ack: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> host_wait_n);

    // R5: local write pulse coincides with the acknowledge
    a_r5_pulse_inside_ack: assert property (@(posedge clk) disable iff (rst)
        loc_wr_valid |-> host_wait_n);
endmodule

// File: tb/epp_responder_bench.sv
module epp_responder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_astb_n = 1'b1, host_dstb_n = 1'b1, host_wr_n = 1'b1;
    logic       host_wait_n;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe, host_irq;
    logic [2:0] host_status;
    logic       loc_wr_valid;
    logic [7:0] loc_wr_data;
    logic [7:0] loc_rd_data = 8'h00;
    logic [7:0] loc_addr;
    logic       loc_irq_set = 1'b0, loc_gpo_we = 1'b0;
    logic [2:0] loc_gpo_din = 3'b000;

    int total = 0, bad = 0, pulses = 0;
    logic [7:0] last_wr = 8'h00;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    epp_responder u_epp_responder (
        .clk(clk), .rst(rst),
        .host_astb_n(host_astb_n), .host_dstb_n(host_dstb_n), .host_wr_n(host_wr_n),
        .host_wait_n(host_wait_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .host_irq(host_irq), .host_status(host_status),
        .loc_wr_valid(loc_wr_valid), .loc_wr_data(loc_wr_data), .loc_rd_data(loc_rd_data),
        .loc_addr(loc_addr), .loc_irq_set(loc_irq_set), .loc_gpo_we(loc_gpo_we),
        .loc_gpo_din(loc_gpo_din)
    );

    always @(posedge clk) begin
        #1;
        if (!rst && loc_wr_valid) begin
            pulses++;
            last_wr = loc_wr_data;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic host_cycle(input bit use_a, input bit use_both, input bit is_w,
                              input logic [7:0] wb, output logic [7:0] rb,
                              output int up, output int dn,
                              output bit oe_mid, output bit oe_after);
        @(negedge clk);
        host_wr_n = !is_w;
        bus_in    = is_w ? wb : ~wb;
        @(negedge clk);
        if (use_a || use_both) host_astb_n = 1'b0;
        if (!use_a || use_both) host_dstb_n = 1'b0;
        up = 0;
        do begin
            @(negedge clk);
            up++;
        end while (!host_wait_n && up < 20);
        rb     = bus_out;
        oe_mid = bus_oe;
        host_astb_n = 1'b1;
        host_dstb_n = 1'b1;
        @(negedge clk);
        oe_after = bus_oe;
        dn = 1;
        while (host_wait_n && dn < 20) begin
            @(negedge clk);
            dn++;
        end
        host_wr_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rb;
        int up, dn, p0;
        bit om, oa;
        logic [7:0] exp_rd;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 wait_n", host_wait_n, 0);
        chk("R1 oe", bus_oe, 0);
        chk("R1 irq", host_irq, 0);
        chk("R1 addr", loc_addr, 0);
        chk("R1 status", host_status, 0);
        chk("R1 wr_valid", loc_wr_valid, 0);

        for (int v = 0; v < 256; v++) begin
            // R4 address write
            p0 = pulses;
            host_cycle(1, 0, 1, v[7:0], rb, up, dn, om, oa);
            chk("R2 ack latency", up, LAT);
            chk("R3 release latency", dn, LAT);
            chk("R4 addr load", loc_addr, v);
            chk("R4 no pulse", pulses, p0);
            chk("R8 no oe on write", om, 0);
            // R6 address read
            host_cycle(1, 0, 0, 8'h00, rb, up, dn, om, oa);
            chk("R6 addr readback", rb, v);
            chk("R6 oe during read", om, 1);
            chk("R8 oe release", oa, 0);
            chk("R3 release latency rd", dn, LAT);
            // R5 data write
            p0 = pulses;
            host_cycle(0, 0, 1, v[7:0] ^ 8'h5A, rb, up, dn, om, oa);
            chk("R5 one pulse", pulses, p0 + 1);
            chk("R5 pulse data", last_wr, v[7:0] ^ 8'h5A);
            chk("R5 addr kept", loc_addr, v);
            chk("R2 ack latency dw", up, LAT);
            // R7 data read
            exp_rd = 8'((v * 7 + 3) & 255);
            loc_rd_data = exp_rd;
            host_cycle(0, 0, 0, 8'h00, rb, up, dn, om, oa);
            chk("R7 data read", rb, exp_rd);
            chk("R8 oe data read", om, 1);
            chk("R8 oe release dr", oa, 0);
        end

        // R10 status register walk
        for (int g = 0; g < 8; g++) begin
            @(negedge clk);
            loc_gpo_we  = 1'b1;
            loc_gpo_din = g[2:0];
            @(negedge clk);
            loc_gpo_we  = 1'b0;
            loc_gpo_din = ~g[2:0];
            chk("R10 status load", host_status, g);
            @(negedge clk);
            chk("R10 status hold", host_status, g);
        end

        // R9 interrupt set, hold, clear
        @(negedge clk);
        loc_irq_set = 1'b1;
        @(negedge clk);
        loc_irq_set = 1'b0;
        chk("R9 irq set", host_irq, 1);
        host_cycle(1, 0, 0, 8'h00, rb, up, dn, om, oa);
        chk("R9 irq held addr read", host_irq, 1);
        host_cycle(0, 0, 1, 8'h11, rb, up, dn, om, oa);
        chk("R9 irq held data write", host_irq, 1);
        host_cycle(1, 0, 1, 8'h22, rb, up, dn, om, oa);
        chk("R9 irq held addr write", host_irq, 1);
        host_cycle(0, 0, 0, 8'h00, rb, up, dn, om, oa);
        chk("R9 irq cleared", host_irq, 0);

        // R11 both strobes together
        p0 = pulses;
        host_cycle(1, 1, 1, 8'hC3, rb, up, dn, om, oa);
        chk("R11 addr wins", loc_addr, 8'hC3);
        chk("R11 no data pulse", pulses, p0);
        host_cycle(1, 1, 0, 8'h00, rb, up, dn, om, oa);
        chk("R11 read addr path", rb, 8'hC3);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule